// File: doc/BRIEF.md
# Fractionally Trimmed Nanosecond Time Counter

This block keeps a free-running 40-bit nanosecond time of day for a network timestamping unit. Each tick of the 8 ns reference clock adds a nominal 8 ns. A 32-bit sub-nanosecond fraction register accumulates a signed correction on top of that step. When the fraction carries past one nanosecond, that tick adds 9 ns. When it borrows below zero, that tick adds 7 ns. Software trims the frequency this way in parts-per-billion steps: one ppb corresponds to 2^26 / 1953125 fraction units per tick, and the largest supported trim is 62,499,999 ppb. The live count is driven on `cur_time_ns` for capture logic.

Software reaches the counter through a simple register strobe interface. There are five registers:

| Address | Register | Contents |
|---|---|---|
| 0 | fraction | 32-bit sub-nanosecond fraction |
| 1 | time low | time bits 31:0 |
| 2 | time high | time bits 39:32 in bits 7:0 |
| 3 | trim | bit 31 sign, bits 30:0 magnitude |
| 4 | control | bit 31 halts the timer |

To set the time, software writes the low word first and then the high word. The low word is only staged; the high-word write commits the whole 40-bit value.

To read the time coherently, software reads the fraction register first. That read freezes a snapshot of the whole time, and the low and high words then return the snapshot. Reading the high word releases the snapshot.

Top module: `ptp_frac_timer`

## Requirements
- R1: After reset the time, the fraction and the trim register are all zero, and the control register reads 0, meaning the timer is running.
- R2: While running with a trim magnitude (bits 30:0) of zero, the time grows by exactly 8 every clock cycle.
- R3: With trim bit 31 clear, each running cycle adds the magnitude to the fraction modulo 2^32. A cycle whose addition overflows 2^32 adds 9 to the time; every other cycle adds 8.
- R4: With trim bit 31 set, each running cycle subtracts the magnitude from the fraction modulo 2^32. A cycle whose subtraction goes below zero adds 7 to the time; every other cycle adds 8.
- R5: The time wraps modulo 2^40. A read of address 2 returns time bits 39:32 in bits 7:0, and bits 31:8 read as zero.
- R6: Writing control bit 31 as 1 freezes both time and fraction. Writing 0 resumes counting on the next cycle.
- R7: A write to address 1 only stages a low word and leaves the time unchanged. A write to address 2 loads the time with {wdata[7:0], staged low word}.
- R8: A read of address 0 returns the fraction and freezes a snapshot of the time. Later reads of addresses 1 and 2 return the snapshot, until address 2 has been read.
- R9: With no snapshot pending, reads of addresses 1 and 2 return the live time.
- R10: Read data appears on `reg_rdata` the cycle after the read strobe. Address 3 reads back the trim register, and address 4 reads back the halt flag in bit 31.
- R11: A write to address 0 sets the fraction to the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 ns reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| cur_time_ns | output | 40 | Live nanosecond time |

## Verification
A write takes effect at the clock edge that samples its strobe. The time step of that same edge still uses the old trim and halt state. So a run that is started and stopped by two control writes N cycles apart advances the time by exactly N steps. Read data is registered, so each register read is sampled at the falling edge after the strobe's rising edge. A snapshot holds the time as it stood before the step of the edge that sampled the fraction read, and the bench predicts the live value from the number of edges counted since the run was enabled. Expected times and fractions for each trim case come from closed-form carry and borrow counts over N cycles, not from stepping a copy of the logic.

// File: rtl/ptp_frac_pkg.sv
package ptp_frac_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_FRAC    = 3'd0,
        REG_TIME_LO = 3'd1,
        REG_TIME_HI = 3'd2,
        REG_TRIM    = 3'd3,
        REG_CTRL    = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/ptp_frac_accum.sv
module ptp_frac_accum #(
    parameter int FRAC_W       = 32,
    parameter int BASE_STEP_NS = 8,
    localparam int STEP_W      = $clog2(BASE_STEP_NS + 2)
) (
    input  logic [FRAC_W-1:0] frac_q,
    input  logic [FRAC_W-1:0] trim,
    output logic [FRAC_W-1:0] frac_next,
    output logic [STEP_W-1:0] step_ns
);
    // trim: MSB is the sign (1 = slow down), remaining bits the magnitude
    logic              trim_neg;
    logic [FRAC_W-1:0] trim_mag;
    logic [FRAC_W:0]   sum_w;
    logic [FRAC_W:0]   dif_w;

    always_comb begin
        trim_neg = trim[FRAC_W-1];
        trim_mag = {1'b0, trim[FRAC_W-2:0]};
        sum_w    = {1'b0, frac_q} + {1'b0, trim_mag};
        dif_w    = {1'b0, frac_q} - {1'b0, trim_mag};
        if (trim_neg) begin
            frac_next = dif_w[FRAC_W-1:0];
            step_ns   = STEP_W'(BASE_STEP_NS) - STEP_W'(dif_w[FRAC_W]);
        end else begin
            frac_next = sum_w[FRAC_W-1:0];
            step_ns   = STEP_W'(BASE_STEP_NS) + STEP_W'(sum_w[FRAC_W]);
        end
    end
endmodule

// File: rtl/ptp_read_mux.sv
module ptp_read_mux
    import ptp_frac_pkg::*;
#(
    parameter int NS_W   = 40,
    parameter int WORD_W = 32,
    localparam int HI_W  = NS_W - WORD_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NS_W-1:0]   tod,
    input  logic [NS_W-1:0]   snap,
    input  logic              snap_vld,
    input  logic [WORD_W-1:0] frac,
    input  logic [WORD_W-1:0] trim,
    input  logic              halt,
    output logic [WORD_W-1:0] rdata
);
    logic [NS_W-1:0] src;

    always_comb begin
        src   = snap_vld ? snap : tod;
        rdata = '0;
        case (addr)
            REG_FRAC:    rdata = frac;
            REG_TIME_LO: rdata = src[WORD_W-1:0];
            REG_TIME_HI: rdata[HI_W-1:0] = src[NS_W-1:WORD_W];
            REG_TRIM:    rdata = trim;
            REG_CTRL:    rdata[WORD_W-1] = halt;
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/ptp_frac_timer.sv
module ptp_frac_timer
    import ptp_frac_pkg::*;
#(
    parameter int NS_W         = 40,
    parameter int WORD_W       = 32,
    parameter int BASE_STEP_NS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [39:0]       cur_time_ns
);
    localparam int HI_W   = NS_W - WORD_W;
    localparam int STEP_W = $clog2(BASE_STEP_NS + 2);

    typedef struct packed {
        logic [NS_W-1:0]   tod;
        logic [WORD_W-1:0] frac;
        logic [WORD_W-1:0] trim;
        logic              halt;
        logic [WORD_W-1:0] lo_stage;
        logic [NS_W-1:0]   snap;
        logic              snap_vld;
        logic [WORD_W-1:0] rdata;
    } tmr_state_t;

    tmr_state_t        st_d, st_q;
    logic [WORD_W-1:0] frac_nxt;
    logic [STEP_W-1:0] step_ns;
    logic [WORD_W-1:0] mux_rdata;

    ptp_frac_accum #(
        .FRAC_W       (WORD_W),
        .BASE_STEP_NS (BASE_STEP_NS)
    ) u_accum (
        .frac_q    (st_q.frac),
        .trim      (st_q.trim),
        .frac_next (frac_nxt),
        .step_ns   (step_ns)
    );

    ptp_read_mux #(
        .NS_W   (NS_W),
        .WORD_W (WORD_W)
    ) u_rmux (
        .addr     (reg_addr),
        .tod      (st_q.tod),
        .snap     (st_q.snap),
        .snap_vld (st_q.snap_vld),
        .frac     (st_q.frac),
        .trim     (st_q.trim),
        .halt     (st_q.halt),
        .rdata    (mux_rdata)
    );

    always_comb begin
        st_d = st_q;
        // free-running advance
        if (!st_q.halt) begin
            st_d.tod  = st_q.tod + NS_W'(step_ns);
            st_d.frac = frac_nxt;
        end
        // register writes override the advance
        if (reg_wr) begin
            case (reg_addr)
                REG_FRAC:    st_d.frac     = reg_wdata;
                REG_TIME_LO: st_d.lo_stage = reg_wdata;
                REG_TIME_HI: st_d.tod      = {reg_wdata[HI_W-1:0], st_q.lo_stage};
                REG_TRIM:    st_d.trim     = reg_wdata;
                REG_CTRL:    st_d.halt     = reg_wdata[WORD_W-1];
                default:     ;
            endcase
        end
        // register reads: fraction read freezes, high read releases
        if (reg_rd) begin
            st_d.rdata = mux_rdata;
            if (reg_addr == REG_FRAC) begin
                st_d.snap     = st_q.tod;
                st_d.snap_vld = 1'b1;
            end else if (reg_addr == REG_TIME_HI) begin
                st_d.snap_vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign reg_rdata   = st_q.rdata;
    assign cur_time_ns = st_q.tod;

    // views for the bound checker
    logic              halt_q;
    logic [WORD_W-1:0] trim_q;
    logic [WORD_W-1:0] lo_stage_q;
    logic [NS_W-1:0]   snap_q;
    logic              snap_vld_q;
    assign halt_q     = st_q.halt;
    assign trim_q     = st_q.trim;
    assign lo_stage_q = st_q.lo_stage;
    assign snap_q     = st_q.snap;
    assign snap_vld_q = st_q.snap_vld;
endmodule

// File: rtl/ptp_frac_timer_chk.sv
module ptp_frac_timer_chk #(
    parameter int NS_W   = 40,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [2:0]        reg_addr,
    input logic [WORD_W-1:0] reg_wdata,
    input logic [WORD_W-1:0] reg_rdata,
    input logic [NS_W-1:0]   cur_time_ns,
    input logic              halt_q,
    input logic [WORD_W-1:0] trim_q,
    input logic [WORD_W-1:0] lo_stage_q,
    input logic [NS_W-1:0]   snap_q,
    input logic              snap_vld_q
);
    localparam int HI_W = NS_W - WORD_W;

    logic [NS_W-1:0] prev_time;
    logic [NS_W-1:0] delta;
    logic            hi_wr;
    logic            runs;

    always_ff @(posedge clk) prev_time <= cur_time_ns;

    assign delta = cur_time_ns - prev_time;
    assign hi_wr = reg_wr && (reg_addr == 3'd2);
    assign runs  = !halt_q && !hi_wr;

    AST_NOMINAL_STEP: assert property (@(posedge clk) disable iff (rst)
        (runs && trim_q[WORD_W-2:0] == '0) |=> (delta == NS_W'(8))) else $error("nominal step"); // R2

    AST_POS_TRIM_STEP: assert property (@(posedge clk) disable iff (rst)
        (runs && !trim_q[WORD_W-1]) |=> (delta == NS_W'(8) || delta == NS_W'(9))) else $error("pos step"); // R3

    AST_NEG_TRIM_STEP: assert property (@(posedge clk) disable iff (rst)
        (runs && trim_q[WORD_W-1]) |=> (delta == NS_W'(7) || delta == NS_W'(8))) else $error("neg step"); // R4

    AST_HI_RESERVED: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 3'd2) |=> (reg_rdata[WORD_W-1:HI_W] == '0)) else $error("hi reserved"); // R5

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (halt_q && !hi_wr) |=> $stable(cur_time_ns)) else $error("halt"); // R6

    AST_HI_LOAD: assert property (@(posedge clk) disable iff (rst)
        hi_wr |=> (cur_time_ns == {$past(reg_wdata[HI_W-1:0]), $past(lo_stage_q)})) else $error("hi load"); // R7

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (snap_vld_q && !(reg_rd && (reg_addr == 3'd0 || reg_addr == 3'd2))) |=> (snap_vld_q && $stable(snap_q))) else $error("snap"); // R8
endmodule

bind ptp_frac_timer ptp_frac_timer_chk #(.NS_W(NS_W), .WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .cur_time_ns (cur_time_ns),
    .halt_q      (halt_q),
    .trim_q      (trim_q),
    .lo_stage_q  (lo_stage_q),
    .snap_q      (snap_q),
    .snap_vld_q  (snap_vld_q)
);

// File: tb/ptp_frac_timer_bench.sv
module ptp_frac_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [39:0] cur_time_ns;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    localparam logic [2:0] A_FRAC = 3'd0, A_LO = 3'd1, A_HI = 3'd2, A_TRIM = 3'd3, A_CTRL = 3'd4;
    localparam logic [31:0] HALT = 32'h8000_0000;

    always #5 clk = ~clk;

    ptp_frac_timer u_ptp_frac_timer (
        .clk (clk), .rst (rst), .reg_wr (reg_wr), .reg_rd (reg_rd),
        .reg_addr (reg_addr), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata), .cur_time_ns (cur_time_ns)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // called just after a falling edge; the strobe is sampled by the next rising edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic set_time(input logic [39:0] t);
        wr(A_LO, t[31:0]);
        wr(A_HI, {24'h0, t[39:32]});
    endtask

    // closed-form expectation over n running cycles
    task automatic predict(input logic [39:0] t0, input int n, input logic [31:0] trim,
                           input logic [31:0] f0, output logic [39:0] t_e, output logic [31:0] f_e);
        longint unsigned d, tot, k;
        d = longint'(n) * longint'(trim[30:0]);
        if (!trim[31]) begin
            tot = longint'(f0) + d;
            k   = tot >> 32;
            f_e = tot[31:0];
            t_e = 40'(longint'(t0) + 8 * longint'(n) + k);
        end else begin
            if (d <= longint'(f0)) k = 0;
            else k = (d - longint'(f0) + 64'hFFFF_FFFF) >> 32;
            tot = longint'(f0) + (k << 32) - d;
            f_e = tot[31:0];
            t_e = 40'(longint'(t0) + 8 * longint'(n) - k);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v, lo, hi, f;
        logic [39:0] te;
        logic [31:0] fe;
        logic [31:0] mags [5];
        int          lens [4];
        logic [31:0] f0s  [3];
        mags = '{32'h0, 32'h1, 32'h2000_0000, 32'h7FFF_FFFF, 32'h4000_0001};
        lens = '{1, 3, 7, 16};
        f0s  = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000};

        repeat (3) @(negedge clk);
        chk("R1 time held at zero in reset", 64'(cur_time_ns), 64'h0);
        rst = 1'b0;
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            chk("R2 nominal 8 ns per cycle after reset", 64'(cur_time_ns), 64'(8 * i));
        end
        rd(A_TRIM, v); chk("R1 trim zero after reset", 64'(v), 64'h0);
        rd(A_CTRL, v); chk("R1 control reads running", 64'(v), 64'h0);

        wr(A_CTRL, HALT);
        rd(A_CTRL, v); chk("R10 control readback halt bit", 64'(v), 64'(HALT));

        // sweep of trim sign, magnitude, run length and start fraction
        foreach (mags[m]) for (int s = 0; s < 2; s++) foreach (lens[l]) foreach (f0s[q]) begin
            logic [31:0] trim;
            trim = {s[0], mags[m][30:0]};
            set_time(40'hFF_FFFF_FFC0);
            wr(A_FRAC, f0s[q]);
            wr(A_TRIM, trim);
            wr(A_CTRL, 32'h0);
            repeat (lens[l] - 1) @(negedge clk);
            wr(A_CTRL, HALT);
            predict(40'hFF_FFFF_FFC0, lens[l], trim, f0s[q], te, fe);
            rd(A_FRAC, f);
            rd(A_TIME_LO_ALIAS, lo);
            rd(A_HI, hi);
            if (s == 0) begin
                chk("R3 R11 fraction after positive trim run", 64'(f), 64'(fe));
                chk("R3 time low after positive trim run", 64'(lo), 64'(te[31:0]));
            end else begin
                chk("R4 R11 fraction after negative trim run", 64'(f), 64'(fe));
                chk("R4 time low after negative trim run", 64'(lo), 64'(te[31:0]));
            end
            chk("R5 time high with wrap and zero upper bits", 64'(hi), 64'(te[39:32]));
        end

        rd(A_TRIM, v); chk("R10 trim readback", 64'(v), 64'h4000_0001 | 64'h8000_0000 & 64'(HALT));

        // halted timer stays frozen
        te = cur_time_ns;
        repeat (20) @(negedge clk);
        chk("R6 time frozen while halted", 64'(cur_time_ns), 64'(te));

        // staged low word does not move time; high write commits
        rd(A_LO, lo);
        wr(A_LO, 32'hAAAA_5555);
        rd(A_LO, v); chk("R7 low write alone leaves time", 64'(v), 64'(lo));
        wr(A_HI, 32'h1234_56C3);
        rd(A_HI, v);  chk("R7 high write loads high byte", 64'(v), 64'hC3);
        rd(A_LO, v);  chk("R7 high write loads staged low", 64'(v), 64'hAAAA_5555);

        // coherent snapshot while running
        wr(A_TRIM, 32'h0);
        wr(A_FRAC, 32'h0);
        set_time(40'h12_FFFF_FFF0);
        wr(A_CTRL, 32'h0);
        rd(A_FRAC, f);
        repeat (5) @(negedge clk);
        rd(A_LO, lo); chk("R8 low returns snapshot", 64'(lo), 64'hFFFF_FFF0);
        rd(A_HI, hi); chk("R8 high returns snapshot", 64'(hi), 64'h12);
        rd(A_LO, lo); chk("R9 low live after release", 64'(lo), 64'h30);
        rd(A_HI, hi); chk("R9 high live after release", 64'(hi), 64'h13);
        chk("R6 resumed count reaches output", 64'(cur_time_ns), 64'h13_0000_0040);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    localparam logic [2:0] A_TIME_LO_ALIAS = A_LO;
endmodule